// File: doc/BRIEF.md
# Byte-Serial CRC-32 Engine (Polynomial 0x20044009)

This block computes a 32-bit cyclic redundancy check over a byte stream, one byte per clock. It uses the generator x^32 + x^29 + x^18 + x^14 + x^3 + 1, written 0x20044009 in normal notation. Bits are processed most significant first. There is no reflection and no final XOR, so the register always holds exactly the value a table-driven software routine would return for the same bytes and starting value.

Bytes enter on a valid/ready stream port. Two plain control strobes set the running value:

- `restart_i` reloads the standard starting value 0xFFFFFFFF at the start of a message.
- `seed_load_i` loads an arbitrary 32-bit value from `seed_i`. A caller can store the CRC of one buffer and continue it later over the next buffer.

On a cycle where either strobe is high, the stream port drops ready and the offered byte is not taken. The source keeps the byte and offers it again on a later cycle.

The byte-update network can be built two ways, chosen by a parameter:

- an unrolled chain of eight conditional shift-and-XOR stages;
- a lookup table of 2^DATA_W entries computed at elaboration.

Both variants give the same result.

Top module: `crc32_byte_engine`

## Requirements
- R1: After reset is released, `crc_o` reads 0xFFFFFFFF.
- R2: When `byte_valid_i` and `byte_ready_o` are both high at a clock edge, `crc_o` becomes (old << 8) XOR T[old[31:24] XOR byte]. Here T[i] is found as follows: place i in bits 31:24, then shift left 8 times, and XOR in 0x20044009 after any shift whose pre-shift bit 31 was 1.
- R3: Starting from 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 leave `crc_o` at 0xF33CB7D3. No final inversion or bit reversal is applied.
- R4: On a cycle with no accepted byte and neither strobe high, `crc_o` keeps its value.
- R5: `restart_i` high at an edge sets `crc_o` to 0xFFFFFFFF. It overrides `seed_load_i` and any offered byte.
- R6: `seed_load_i` high at an edge, with `restart_i` low, sets `crc_o` to `seed_i`. An offered byte is not taken on that cycle.
- R7: `byte_ready_o` is low on exactly the cycles where `restart_i` or `seed_load_i` is high, and high on all other cycles. A byte counts as taken only when valid and ready are both high.
- R8: Take the CRC of buffer A, then reload it through `seed_load_i` and run buffer B. The result equals the CRC of A followed by B run in one pass.
- R9: A byte equal to the current bits 31:24 of `crc_o` turns the value into the old value shifted left by 8, with zero fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| restart_i | input | 1 | Reload the 0xFFFFFFFF starting value |
| seed_load_i | input | 1 | Load `seed_i` into the running value |
| seed_i | input | CRC_W | Value to continue from |
| byte_valid_i | input | 1 | A byte is offered |
| byte_ready_o | output | 1 | The offered byte is taken this cycle |
| byte_i | input | DATA_W | Stream byte |
| crc_o | output | CRC_W | Running CRC value |

## Verification
The bench builds two copies side by side with CRC_W=32, DATA_W=8 and the default polynomial and starting value: one with the lookup-table step and one with the unrolled step. A bit-serial reference checks both on every clock. This brings the equivalence of the two networks within reach under long random byte streams, gapped valid, and strobes that collide with offered bytes. The reference vector, the zero-index shift case and the split-buffer chaining case are checked against literal expectations.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic {
    STEP_UNROLLED = 1'b0,
    STEP_LUT      = 1'b1
  } step_impl_e;

  localparam int unsigned DEF_CRC_W  = 32;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/crc_next_calc.sv
module crc_next_calc
  import crc_pkg::*;
#(
  parameter int unsigned CRC_W  = DEF_CRC_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [CRC_W-1:0] POLY = 32'h2004_4009,
  parameter step_impl_e IMPL = STEP_LUT
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int unsigned LUT_N = 2 ** DATA_W;
  localparam int unsigned PAD_W = CRC_W - DATA_W;

  generate
    if (IMPL == STEP_UNROLLED) begin : g_unrolled
      logic [CRC_W-1:0] stage [DATA_W+1];
      assign stage[0] = crc_in ^ {data_in, {PAD_W{1'b0}}};
      for (genvar k = 0; k < DATA_W; k++) begin : g_stage
        assign stage[k+1] = stage[k][CRC_W-1]
                          ? ({stage[k][CRC_W-2:0], 1'b0} ^ POLY)
                          :  {stage[k][CRC_W-2:0], 1'b0};
      end
      assign crc_out = stage[DATA_W];
    end else begin : g_lut
      function automatic logic [CRC_W-1:0] lut_val(input int unsigned idx);
        logic [CRC_W-1:0] acc;
        acc = {idx[DATA_W-1:0], {PAD_W{1'b0}}};
        for (int b = 0; b < int'(DATA_W); b++) begin
          if (acc[CRC_W-1]) acc = {acc[CRC_W-2:0], 1'b0} ^ POLY;
          else              acc = {acc[CRC_W-2:0], 1'b0};
        end
        return acc;
      endfunction

      logic [CRC_W-1:0]  lut [LUT_N];
      logic [DATA_W-1:0] idx;
      for (genvar i = 0; i < LUT_N; i++) begin : g_entry
        assign lut[i] = lut_val(i);
      end
      assign idx     = crc_in[CRC_W-1 -: DATA_W] ^ data_in;
      assign crc_out = {crc_in[PAD_W-1:0], {DATA_W{1'b0}}} ^ lut[idx];
    end
  endgenerate
endmodule

// File: rtl/crc_hold_reg.sv
module crc_hold_reg #(
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CRC_W-1:0] seed,
  input  logic             adv,
  input  logic [CRC_W-1:0] nxt,
  output logic [CRC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= INIT;
    else if (clear) q <= INIT;
    else if (load)  q <= seed;
    else if (adv)   q <= nxt;
  end

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && !adv) |=> $stable(q));

  // R5
  restart_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == INIT));

  // R6
  seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (q == $past(seed)));
endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
  import crc_pkg::*;
#(
  parameter int unsigned CRC_W  = DEF_CRC_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [CRC_W-1:0] POLY = 32'h2004_4009,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFF_FFFF,
  parameter step_impl_e IMPL = STEP_LUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              seed_load_i,
  input  logic [CRC_W-1:0]  seed_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [DATA_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int unsigned PAD_W = CRC_W - DATA_W;

  logic             take;
  logic [CRC_W-1:0] crc_nxt;

  assign byte_ready_o = !(restart_i || seed_load_i);
  assign take         = byte_valid_i && byte_ready_o;

  crc_next_calc #(
    .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .IMPL(IMPL)
  ) u_step (
    .crc_in(crc_o), .data_in(byte_i), .crc_out(crc_nxt)
  );

  crc_hold_reg #(
    .CRC_W(CRC_W), .INIT(INIT)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .clear(restart_i), .load(seed_load_i),
    .seed(seed_i), .adv(take), .nxt(crc_nxt), .q(crc_o)
  );

  // R9
  zero_index_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (byte_i == crc_o[CRC_W-1 -: DATA_W]))
      |=> (crc_o == {$past(crc_o[PAD_W-1:0]), {DATA_W{1'b0}}}));

  // R7
  strobe_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i || seed_load_i) |-> !byte_ready_o);
endmodule

// File: tb/sim_crc32_byte_engine.sv
`timescale 1ns/1ps
module sim_crc32_byte_engine;
  import crc_pkg::*;
  localparam logic [31:0] POLY = 32'h2004_4009;
  localparam logic [31:0] INIT = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic restart = 0, seed_load = 0, bvalid = 0;
  logic [31:0] seed = 0;
  logic [7:0] bdata = 0;
  logic rdy0, rdy1;
  logic [31:0] crc0, crc1;
  int checks = 0, errors = 0;
  logic [31:0] model = INIT;
  string tag = "R1";
  bit live = 0, done = 0;

  always #2.5 clk = ~clk;

  crc32_byte_engine #(.IMPL(STEP_LUT)) u0 (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .seed_load_i(seed_load),
    .seed_i(seed), .byte_valid_i(bvalid), .byte_ready_o(rdy0),
    .byte_i(bdata), .crc_o(crc0));

  crc32_byte_engine #(.IMPL(STEP_UNROLLED)) u1 (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .seed_load_i(seed_load),
    .seed_i(seed), .byte_valid_i(bvalid), .byte_ready_o(rdy1),
    .byte_i(bdata), .crc_o(crc1));

  // bit-serial reference: feed data bits one at a time
  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ d[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin model = INIT; tag = "R1"; end
    else if (restart) begin model = INIT; tag = "R5"; end
    else if (seed_load) begin model = seed; tag = "R6"; end
    else if (bvalid) begin model = ref_step(model, bdata); tag = "R2"; end
    else tag = "R4";
  end

  always @(negedge clk) if (live && rst_n) begin
    check(crc0 == model, tag, crc0, model);
    check(crc1 == model, tag, crc1, model);
    check(rdy0 == !(restart || seed_load), "R7", {31'b0, rdy0}, {31'b0, !(restart || seed_load)});
    check(rdy1 == rdy0, "R7", {31'b0, rdy1}, {31'b0, rdy0});
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [7:0] b);
    bvalid = 1; bdata = b; tick(); bvalid = 0;
  endtask

  task automatic do_restart();
    restart = 1; tick(); restart = 0;
  endtask

  task automatic do_seed(input logic [31:0] s);
    seed_load = 1; seed = s; tick(); seed_load = 0;
  endtask

  initial begin
    logic [31:0] part_a, whole;
    byte unsigned bufa [5] = '{8'h10, 8'hA5, 8'h00, 8'hFF, 8'h3C};
    byte unsigned bufb [4] = '{8'h77, 8'h81, 8'h5E, 8'h02};
    repeat (3) tick();
    rst_n = 1; live = 1; tick();
    check(crc0 == 32'hFFFF_FFFF, "R1", crc0, 32'hFFFF_FFFF);

    // R3 reference vector
    put(8'h01); put(8'h02); put(8'h03); put(8'h04);
    check(crc0 == 32'hF33C_B7D3, "R3", crc0, 32'hF33C_B7D3);
    check(crc1 == 32'hF33C_B7D3, "R3", crc1, 32'hF33C_B7D3);

    // R4 idle hold
    repeat (3) tick();
    check(crc0 == 32'hF33C_B7D3, "R4", crc0, 32'hF33C_B7D3);

    // R9 zero-index shift
    do_seed(32'h1234_5678);
    check(crc0 == 32'h1234_5678, "R6", crc0, 32'h1234_5678);
    put(8'h12);
    check(crc0 == 32'h3456_7800, "R9", crc0, 32'h3456_7800);

    // R5 restart beats byte and seed
    restart = 1; seed_load = 1; seed = 32'hDEAD_BEEF; bvalid = 1; bdata = 8'h55;
    tick(); restart = 0; seed_load = 0; bvalid = 0;
    check(crc0 == 32'hFFFF_FFFF, "R5", crc0, 32'hFFFF_FFFF);

    // R6 seed with byte offered: byte not taken
    seed_load = 1; seed = 32'h0BAD_F00D; bvalid = 1; bdata = 8'h99;
    tick(); seed_load = 0; bvalid = 0;
    check(crc0 == 32'h0BAD_F00D, "R6", crc0, 32'h0BAD_F00D);

    // R8 chaining
    do_restart();
    foreach (bufa[i]) put(bufa[i]);
    part_a = crc0;
    do_restart(); put(8'hEE); put(8'h01);
    do_seed(part_a);
    foreach (bufb[i]) put(bufb[i]);
    whole = INIT;
    foreach (bufa[i]) whole = ref_step(whole, bufa[i]);
    foreach (bufb[i]) whole = ref_step(whole, bufb[i]);
    check(crc0 == whole, "R8", crc0, whole);
    check(crc1 == whole, "R8", crc1, whole);

    // random mixed traffic, R2 R4 R5 R6 R7 checked every clock
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      restart = (r < 3);
      seed_load = (r >= 3 && r < 7);
      seed = $urandom();
      bvalid = ($urandom_range(0, 3) != 0);
      bdata = $urandom();
      tick();
    end
    restart = 0; seed_load = 0; bvalid = 0;
    tick();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(5.0 * 200000);
        errors++; checks++;
        $display("FAIL watchdog R2 actual=%08h expected=%08h", crc0, model);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule